// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter for a small microcontroller. Software reaches it over a byte-wide register bus with four addresses. A prescaler divides the system clock by a fixed parameter. A counter then counts the prescaled ticks up to a terminal value that a four-bit divider field selects. When the counter reaches that value, the block either asks for a system reset or raises an interrupt, as the control register says. Software must keep the counter from expiring by writing a single key byte to the refresh address.

The control register is protected against stray writes. It accepts exactly one write after three specific bytes have arrived, in order, at the unlock address. A static option input, intended to come from a fuse-like configuration bit, forces the watchdog off whatever the enable bit holds.

A status register keeps sticky reset-cause flags and the interrupt-pending flag, and software clears them. The cause flags that the block does not produce itself are set by input pulses.

Top module: `wdt_guard`

## Requirements
- R1: After reset the control register reads 0x04, the status register reads 0x00, and `rst_req` and `irq` are low.
- R2: The control register is at address 1. Bit 6 selects the timeout action (0 = reset request, 1 = interrupt), bit 5 enables the watchdog and bits 3:0 hold the divider. Bits 7 and 4 always read 0, and the enable bit reads back the value that was written.
- R3: A write to address 1 changes the control register only if address 0 has first received 0x55, then 0xAA, then 0x5A. Otherwise the write is ignored.
- R4: A wrong byte written to address 0 at any step of the sequence sends the sequence back to its start, so the whole three-byte sequence must be written again.
- R5: A completed sequence opens a window for one control write only. The next control write after the accepted one is ignored.
- R6: While `opt_force_off` is 1, the watchdog neither counts nor times out, whatever the enable bit holds. When it returns to 0, counting restarts from zero.
- R7: The timeout period is PRESCALE × 2^(divider+10) clock cycles. An accepted control write clears the counter and the prescaler, so the first timeout comes exactly that many cycles after the write.
- R8: Writing exactly 0x55 to address 2 clears the counter and the prescaler, and the period restarts. Any other value written there has no effect on the timing.
- R9: In reset mode a timeout drives `rst_req` high for exactly one cycle, and bit 3 of the status register (watchdog cause) is set from the next cycle on.
- R10: In interrupt mode a timeout sets status bit 7 (pending) one cycle later. `irq` follows that bit, and `rst_req` stays low.
- R11: The status register is at address 3. Bit 0 (power-on), bit 1 (low voltage), bit 2 (software) and bit 4 (power-down) are set by the pulse inputs `set_por`, `set_lvr`, `set_sw` and `set_pd`. Status flags are sticky, and writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged. Addresses 0 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 2 | Register address (0 unlock, 1 control, 2 refresh, 3 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| opt_force_off | input | 1 | Static option: 1 forces the watchdog off |
| set_por | input | 1 | Pulse that sets the power-on cause flag |
| set_lvr | input | 1 | Pulse that sets the low-voltage cause flag |
| set_sw | input | 1 | Pulse that sets the software cause flag |
| set_pd | input | 1 | Pulse that sets the power-down cause flag |
| rst_req | output | 1 | One-cycle watchdog reset request |
| irq | output | 1 | Watchdog interrupt pending |

## Verification
The assertions check on every cycle that:
- a control write without an open window leaves the register unchanged;
- the window closes after one accepted write;
- a timeout pulse lasts a single cycle;
- the option input suppresses reset requests;
- every reset request sets the watchdog flag;
- the pending flag only rises in interrupt mode.

The exact timeout latency can only be shown by the bench's scenarios, because it depends on the divider, on refresh timing and on release of the override. The same holds for the restart of the unlock sequence after a wrong byte and for write-1-to-clear of each flag. The bench predicts each pulse's arrival cycle and compares it with the cycle in which the pulse is seen.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int DIV_W = 4;

    localparam logic [1:0] ADDR_KEY  = 2'd0;
    localparam logic [1:0] ADDR_CTL  = 2'd1;
    localparam logic [1:0] ADDR_FEED = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [7:0] KEY_THIRD  = 8'h5A;
    localparam logic [7:0] FEED_KEY   = 8'h55;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_ONE,
        LK_TWO,
        LK_OPEN
    } lock_state_t;

    typedef struct packed {
        logic             act_irq;
        logic             en;
        logic [DIV_W-1:0] div;
    } ctl_t;

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       ctl_wr,
    output logic       open_win
);

    typedef struct packed {
        lock_state_t st;
    } lock_regs_t;

    lock_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (key_wr) begin
            case (r_q.st)
                LK_ONE:  r_d.st = (key_data == KEY_SECOND) ? LK_TWO  : LK_IDLE;
                LK_TWO:  r_d.st = (key_data == KEY_THIRD)  ? LK_OPEN : LK_IDLE;
                default: r_d.st = (key_data == KEY_FIRST)  ? LK_ONE  : LK_IDLE;
            endcase
        end else if (ctl_wr && r_q.st == LK_OPEN) begin
            r_d.st = LK_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: LK_IDLE};
        else        r_q <= r_d;
    end

    assign open_win = (r_q.st == LK_OPEN);

    // R5: the window admits a single control write
    a_r5_single_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !key_wr && open_win) |=> !open_win);

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_regs_t;

    pre_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear || !run)            r_d.cnt = '0;
        else if (r_q.cnt == PRE_LAST) r_d.cnt = '0;
        else                          r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = run && !clear && (r_q.cnt == PRE_LAST);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_guard_pkg::*;
#(
    parameter int BASE_EXP = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             expire
);

    localparam int CNT_W = BASE_EXP + (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             exp;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;
    logic [CNT_W-1:0] term;

    // 2^(div+BASE_EXP)-1; the top divider wraps the shift to 0, giving all ones
    assign term = (CNT_W'(1) << (CNT_W'(div) + CNT_W'(BASE_EXP))) - CNT_W'(1);

    always_comb begin
        r_d = r_q;
        r_d.exp = 1'b0;
        if (clear || !run) begin
            r_d.cnt = '0;
        end else if (tick) begin
            if (r_q.cnt == term) begin
                r_d.cnt = '0;
                r_d.exp = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign expire = r_q.exp;

    // R7: a timeout is a single-cycle pulse
    a_r7_expire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int PRESCALE = 4,
    parameter int BASE_EXP = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       opt_force_off,
    input  logic       set_por,
    input  logic       set_lvr,
    input  logic       set_sw,
    input  logic       set_pd,
    output logic       rst_req,
    output logic       irq
);

    localparam ctl_t CTL_RESET = '{act_irq: 1'b0, en: 1'b0, div: DIV_W'(4)};

    typedef struct packed {
        ctl_t       ctl;
        logic [4:0] cause;
        logic       pend;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic key_wr, ctl_wr, stat_wr, feed_ok, ctl_ok;
    logic open_win, run, clear, tick, expire;

    assign key_wr  = wr_en && (addr == ADDR_KEY);
    assign ctl_wr  = wr_en && (addr == ADDR_CTL);
    assign stat_wr = wr_en && (addr == ADDR_STAT);
    assign feed_ok = wr_en && (addr == ADDR_FEED) && (wdata == FEED_KEY);
    assign ctl_ok  = ctl_wr && open_win;
    assign run     = r_q.ctl.en && !opt_force_off;
    assign clear   = ctl_ok || feed_ok;

    wdt_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (wdata),
        .ctl_wr   (ctl_wr),
        .open_win (open_win)
    );

    wdt_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (clear),
        .tick  (tick)
    );

    wdt_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clear  (clear),
        .tick   (tick),
        .div    (r_q.ctl.div),
        .expire (expire)
    );

    assign rst_req = expire && !r_q.ctl.act_irq;
    assign irq     = r_q.pend;

    always_comb begin
        r_d = r_q;
        if (ctl_ok) begin
            r_d.ctl.act_irq = wdata[6];
            r_d.ctl.en      = wdata[5];
            r_d.ctl.div     = wdata[DIV_W-1:0];
        end
        if (stat_wr) begin
            r_d.cause = r_q.cause & ~wdata[4:0];
            if (wdata[7]) r_d.pend = 1'b0;
        end
        r_d.cause = r_d.cause | {set_pd, rst_req, set_sw, set_lvr, set_por};
        if (expire && r_q.ctl.act_irq) r_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctl: CTL_RESET, cause: 5'd0, pend: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            ADDR_CTL:  rdata = {1'b0, r_q.ctl.act_irq, r_q.ctl.en, 1'b0, r_q.ctl.div};
            ADDR_STAT: rdata = {r_q.pend, 2'b00, r_q.cause};
            default:   rdata = 8'h00;
        endcase
    end

    // R3: a locked control write leaves the register alone
    a_r3_locked_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !open_win) |=> (r_q.ctl == $past(r_q.ctl)));

    // R6: the option input suppresses reset requests
    a_r6_force_off: assert property (@(posedge clk) disable iff (!rst_n)
        opt_force_off |=> !rst_req);

    // R9: every reset request leaves the watchdog cause flag set
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> r_q.cause[3]);

    // R10: pending only rises while interrupt mode is selected
    a_r10_pend_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.pend) |-> $past(r_q.ctl.act_irq));

endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int PRE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       opt_force_off = 1'b0;
    logic       set_por = 1'b0, set_lvr = 1'b0, set_sw = 1'b0, set_pd = 1'b0;
    logic       rst_req, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    bit done = 0;

    typedef struct {
        bit    is_irq;
        int    at;
        string req;
    } exp_t;
    exp_t expq[$];

    wdt_guard #(.PRESCALE(PRE), .BASE_EXP(10)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .opt_force_off(opt_force_off), .set_por(set_por),
        .set_lvr(set_lvr), .set_sw(set_sw), .set_pd(set_pd),
        .rst_req(rst_req), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, output int c);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        c = cyc;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    task automatic unlock();
        int c;
        wr(2'd0, 8'h55, c);
        wr(2'd0, 8'hAA, c);
        wr(2'd0, 8'h5A, c);
    endtask

    task automatic expect_pulse(bit is_irq, int at, string req);
        expq.push_back('{is_irq: is_irq, at: at, req: req});
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
    endtask

    // monitor: pops the expected pulse and compares its arrival cycle
    logic irq_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rst_req || (irq && !irq_prev)) begin
                pulses++;
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R6: unexpected %s at cycle %0d, actual pulse expected none",
                             rst_req ? "rst_req" : "irq", cyc);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.is_irq != (!rst_req) || e.at != cyc) begin
                        errors++;
                        $display("FAIL %s: actual %s at %0d expected %s at %0d", e.req,
                                 rst_req ? "rst_req" : "irq", cyc,
                                 e.is_irq ? "irq" : "rst_req", e.at);
                    end
                end
            end
            irq_prev <= irq;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung run expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, d); check("R1 ctl", d, 8'h04);
        rd(2'd3, d); check("R1 stat", d, 8'h00);
        check("R1 outputs", {6'd0, rst_req, irq}, 8'h00);

        // R3 write without unlock is ignored
        wr(2'd1, 8'h2F, c);
        rd(2'd1, d); check("R3 locked", d, 8'h04);
        // R3 wrong final key
        wr(2'd0, 8'h55, c); wr(2'd0, 8'hAA, c); wr(2'd0, 8'h5B, c);
        wr(2'd1, 8'h2F, c);
        rd(2'd1, d); check("R3 bad key", d, 8'h04);
        // R4 wrong byte mid-sequence restarts the sequence
        wr(2'd0, 8'h55, c); wr(2'd0, 8'h12, c); wr(2'd0, 8'hAA, c); wr(2'd0, 8'h5A, c);
        wr(2'd1, 8'h2F, c);
        rd(2'd1, d); check("R4 restart", d, 8'h04);

        // R2 accepted write, unused bits read 0; force off held high
        opt_force_off = 1'b1;
        unlock();
        wr(2'd1, 8'hFF, c);
        rd(2'd1, d); check("R2 layout", d, 8'h6F);
        // R5 second write ignored
        wr(2'd1, 8'h00, c);
        rd(2'd1, d); check("R5 relock", d, 8'h6F);
        unlock();
        wr(2'd1, 8'h20, c);
        rd(2'd1, d); check("R2 enable readback", d, 8'h20);

        // R6 override: enabled but forced off, no pulse for over a period
        repeat (5000) @(negedge clk);
        check("R6 no pulse", 8'(pulses), 8'd0);

        // R6/R7 release the override: period restarts from zero
        @(negedge clk);
        opt_force_off = 1'b0;
        c = cyc;
        expect_pulse(0, c + 1024*PRE, "R7");
        repeat (2000) @(negedge clk);
        wr(2'd2, 8'h33, c);              // R8: ignored value
        drain();
        rd(2'd3, d); check("R9 cause flag", d, 8'h08);
        repeat (2000) @(negedge clk);
        wr(2'd2, 8'h55, c);              // R8: valid refresh
        expect_pulse(0, c + 1024*PRE, "R8");
        drain();
        opt_force_off = 1'b1;

        // R11 flag clearing and setting
        wr(2'd3, 8'h08, c);
        rd(2'd3, d); check("R11 w1c wdt", d, 8'h00);
        @(negedge clk);
        set_por = 1; set_lvr = 1; set_sw = 1; set_pd = 1;
        @(negedge clk);
        set_por = 0; set_lvr = 0; set_sw = 0; set_pd = 0;
        rd(2'd3, d); check("R11 set inputs", d, 8'h17);
        wr(2'd3, 8'h01, c);
        rd(2'd3, d); check("R11 clear por", d, 8'h16);
        wr(2'd3, 8'h00, c);
        rd(2'd3, d); check("R11 zero write", d, 8'h16);
        wr(2'd3, 8'h16, c);
        rd(2'd3, d); check("R11 clear rest", d, 8'h00);
        rd(2'd0, d); check("R11 key reads 0", d, 8'h00);

        // R10 interrupt mode, divider 1
        unlock();
        wr(2'd1, 8'h61, c);
        rd(2'd1, d); check("R2 irq ctl", d, 8'h61);
        @(negedge clk);
        opt_force_off = 1'b0;
        c = cyc;
        expect_pulse(1, c + 2048*PRE + 1, "R10");
        drain();
        rd(2'd3, d); check("R10 pending only", d, 8'h80);
        wr(2'd3, 8'h80, c);
        rd(2'd3, d); check("R10 pending cleared", d, 8'h00);
        check("R10 irq low", {7'd0, irq}, 8'h00);
        opt_force_off = 1'b1;

        repeat (20) @(negedge clk);
        check("R7 queue empty", 8'(expq.size()), 8'd0);
        finish_run();
    end

endmodule